// File: doc/BRIEF.md
# Shared Interrupt Line Router

This block sits between the expansion slots of a peripheral bus and the request inputs of an interrupt priority controller. Every slot offers four active-low interrupt pins, and several functions may pull the same pin low at once. The block brings the pins into the local clock domain. It then turns each pin onto one of four shared lines by rotating the pin index by the slot number. The shared line is asserted while any source tied to it is pulled low.

Each shared line has a routing entry. The entry holds a target IRQ number and a disable bit. A write that names a target outside the permitted IRQ set is dropped. Each IRQ output is the OR of all enabled lines routed to it. The output then goes through a per-IRQ trigger stage. In level mode the output follows the merged request. In edge mode the output gives a single-cycle pulse when the merged request rises. Older edge-sensing sources and shared level sources can therefore sit on the same controller.

Top module: `irq_line_router`

## Requirements
- R1: After reset every IRQ output is low and every IRQ is in level mode. Shared line l (0..3) is enabled and routed to IRQ BASE_IRQ+l, with BASE_IRQ defaulting to 9.
- R2: The pin at bit s*4+p of `slot_int_n` (slot s, pin p, where p=0 is the first pin) feeds shared line (p+s) mod 4.
- R3: A shared line is active while at least one pin mapped to it is low. Pins are active low, and a pin that is high contributes nothing.
- R4: In level mode (mode bit 0), an IRQ output equals its merged request. A pin change shows up at the output after the third rising clock edge following it: two synchronizer stages and one output register.
- R5: In edge mode (mode bit 1), an IRQ output is high for exactly one cycle after its merged request rises. It stays low while the request is held and when the request falls.
- R6: A route write (`route_we`, with `route_dis`=0 and a permitted `route_irq`) takes effect on the next clock edge. After that the line drives only the new IRQ.
- R7: A route written with `route_dis`=1 makes that line drive no IRQ output.
- R8: An enabled route write whose target bit is 0 in ALLOWED_MASK is ignored, and the previous route stays in force. The default mask permits IRQs 3, 4, 5, 7, 9, 10, 11, 12, 14 and 15.
- R9: When several enabled lines are routed to the same IRQ, that IRQ's request is the OR of those lines.
- R10: An IRQ with no enabled line routed to it stays low whatever the pins do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_int_n | input | NUM_SLOTS*4 | Active-low slot interrupt pins, bit s*4+p |
| route_we | input | 1 | Route entry write strobe |
| route_line | input | 2 | Shared line whose entry is written |
| route_dis | input | 1 | Disable bit for the written entry |
| route_irq | input | IRQ_W | Target IRQ number for the written entry |
| mode_we | input | 1 | Trigger mode write strobe |
| mode_irq | input | IRQ_W | IRQ whose trigger mode is written |
| mode_edge | input | 1 | 1 = edge mode, 0 = level mode |
| irq_out | output | NUM_IRQ | Active-high requests to the controller |

## Verification
The bench drives pins on every slot, including pins from different slots that fold onto the same line. A wrong rotation would light the wrong IRQ. A plain AND in place of the sharing OR would drop a request while one of two sharers is still low. Edge mode is tested by holding a request and then releasing it, which catches a design that repeats the pulse or pulses on the falling edge. The routing tests cover three cases: a write to a forbidden IRQ, which a careless design would accept and so move the request; a disabled line, which a faulty design would still deliver; and two lines merged onto one IRQ, where a wrong design keeps only the last line matched.

// File: rtl/irq_route_pkg.sv
// Package: shared constants, trigger-mode encoding and the slot rotation
// function for the interrupt line router.
package irq_route_pkg;

    localparam int PINS_PER_SLOT = 4;
    localparam int NUM_LINES     = 4;
    localparam int LINE_W        = 2;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trig_mode_e;

    // Rotate pin p of slot s onto a shared line index.
    function automatic int rot_line(input int slot, input int pin);
        return (pin + slot) % NUM_LINES;
    endfunction

endpackage

// File: rtl/pin_sync_merge.sv
// Module: pin_sync_merge
// Purpose: synchronizes the active-low slot pins, rotates every pin onto
// its shared line, and ORs all sources of a line into an active-high request.
// Assumes: pins are asynchronous, and an idle pin is high (reset value 1).
module pin_sync_merge
    import irq_route_pkg::*;
#(
    parameter int NUM_SLOTS   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] pin_n,
    output logic [NUM_LINES-1:0]               line_req
);
    localparam int PIN_W = NUM_SLOTS * PINS_PER_SLOT;

    logic [SYNC_STAGES-1:0][PIN_W-1:0] sync_q;

    // Synchronizer chain; idle value is all ones (inactive).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q[0] <= pin_n;
            for (int k = 1; k < SYNC_STAGES; k++) begin
                sync_q[k] <= sync_q[k-1];
            end
        end
    end

    logic [PIN_W-1:0] pin_act;
    assign pin_act = ~sync_q[SYNC_STAGES-1];

    // Per line: OR of every synchronized pin the rotation maps onto it.
    genvar gl;
    generate
        for (gl = 0; gl < NUM_LINES; gl++) begin : g_line
            always_comb begin
                line_req[gl] = 1'b0;
                for (int s = 0; s < NUM_SLOTS; s++) begin
                    for (int p = 0; p < PINS_PER_SLOT; p++) begin
                        if (rot_line(s, p) == gl && pin_act[s*PINS_PER_SLOT+p]) begin
                            line_req[gl] = 1'b1;
                        end
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/route_table.sv
// Module: route_table
// Purpose: holds one routing entry (disable bit, target IRQ) per shared
// line, and forms each IRQ request as the OR of the enabled lines aimed at it.
// Assumes: an enabled write whose target is outside ALLOWED_MASK is dropped.
module route_table
    import irq_route_pkg::*;
#(
    parameter int                NUM_IRQ      = 16,
    parameter logic [NUM_IRQ-1:0] ALLOWED_MASK = 16'hDEB8,
    parameter int                BASE_IRQ     = 9,
    localparam int               IRQ_W        = $clog2(NUM_IRQ)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [LINE_W-1:0]              wr_line,
    input  logic                           wr_dis,
    input  logic [IRQ_W-1:0]               wr_irq,
    input  logic [NUM_LINES-1:0]           line_req,
    output logic [NUM_IRQ-1:0]             irq_req,
    output logic [NUM_LINES-1:0]           dis_q,
    output logic [NUM_LINES-1:0][IRQ_W-1:0] tgt_q
);
    logic wr_ok;

    // A write is accepted if it disables the line or targets a permitted IRQ.
    assign wr_ok = wr_en && (wr_dis || ALLOWED_MASK[wr_irq]);

    // Routing registers, with default line l -> BASE_IRQ + l, enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < NUM_LINES; l++) begin
                dis_q[l] <= 1'b0;
                tgt_q[l] <= IRQ_W'(BASE_IRQ + l);
            end
        end else if (wr_ok) begin
            dis_q[wr_line] <= wr_dis;
            tgt_q[wr_line] <= wr_irq;
        end
    end

    // Merge: each IRQ collects every enabled, active line routed to it.
    genvar gi;
    generate
        for (gi = 0; gi < NUM_IRQ; gi++) begin : g_irq
            always_comb begin
                irq_req[gi] = 1'b0;
                for (int l = 0; l < NUM_LINES; l++) begin
                    if (!dis_q[l] && tgt_q[l] == IRQ_W'(gi) && line_req[l]) begin
                        irq_req[gi] = 1'b1;
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/trigger_stage.sv
// Module: trigger_stage
// Purpose: per-IRQ trigger mode register and output register. Level mode
// passes the request through; edge mode emits a one-cycle rising-edge pulse.
// Assumes: the previous request is tracked in both modes, so a mode change
// raises no spurious pulse for a request that was already held.
module trigger_stage
    import irq_route_pkg::*;
#(
    parameter int  NUM_IRQ = 16,
    localparam int IRQ_W   = $clog2(NUM_IRQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_we,
    input  logic [IRQ_W-1:0]   mode_irq,
    input  logic               mode_edge,
    input  logic [NUM_IRQ-1:0] req,
    output logic [NUM_IRQ-1:0] irq_out,
    output logic [NUM_IRQ-1:0] mode_q
);
    logic [NUM_IRQ-1:0] prev_q;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_IRQ; gi++) begin : g_trig
            // Mode bit for this IRQ, written by index.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mode_q[gi] <= TRIG_LEVEL;
                end else if (mode_we && mode_irq == IRQ_W'(gi)) begin
                    mode_q[gi] <= mode_edge;
                end
            end

            // Output and history registers for this IRQ.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prev_q[gi]  <= 1'b0;
                    irq_out[gi] <= 1'b0;
                end else begin
                    prev_q[gi]  <= req[gi];
                    irq_out[gi] <= (mode_q[gi] == TRIG_EDGE) ? (req[gi] && !prev_q[gi])
                                                              : req[gi];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/irq_line_router.sv
// Module: irq_line_router (top)
// Purpose: routes four rotated, shared, active-low interrupt lines from
// several slots onto active-high IRQ outputs, each with its own trigger mode.
// Assumes: the configuration inputs are synchronous to clk.
module irq_line_router
    import irq_route_pkg::*;
#(
    parameter int                 NUM_SLOTS    = 4,
    parameter int                 NUM_IRQ      = 16,
    parameter int                 SYNC_STAGES  = 2,
    parameter logic [NUM_IRQ-1:0] ALLOWED_MASK = 16'hDEB8,
    parameter int                 BASE_IRQ     = 9,
    localparam int                IRQ_W        = $clog2(NUM_IRQ)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] slot_int_n,
    input  logic                               route_we,
    input  logic [LINE_W-1:0]                  route_line,
    input  logic                               route_dis,
    input  logic [IRQ_W-1:0]                   route_irq,
    input  logic                               mode_we,
    input  logic [IRQ_W-1:0]                   mode_irq,
    input  logic                               mode_edge,
    output logic [NUM_IRQ-1:0]                 irq_out
);
    logic [NUM_LINES-1:0]            line_req;
    logic [NUM_IRQ-1:0]              irq_req;
    logic [NUM_LINES-1:0]            dis_q;
    logic [NUM_LINES-1:0][IRQ_W-1:0] tgt_q;
    logic [NUM_IRQ-1:0]              mode_q;

    pin_sync_merge #(
        .NUM_SLOTS   (NUM_SLOTS),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_n    (slot_int_n),
        .line_req (line_req)
    );

    route_table #(
        .NUM_IRQ      (NUM_IRQ),
        .ALLOWED_MASK (ALLOWED_MASK),
        .BASE_IRQ     (BASE_IRQ)
    ) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (route_we),
        .wr_line  (route_line),
        .wr_dis   (route_dis),
        .wr_irq   (route_irq),
        .line_req (line_req),
        .irq_req  (irq_req),
        .dis_q    (dis_q),
        .tgt_q    (tgt_q)
    );

    trigger_stage #(
        .NUM_IRQ (NUM_IRQ)
    ) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_we   (mode_we),
        .mode_irq  (mode_irq),
        .mode_edge (mode_edge),
        .req       (irq_req),
        .irq_out   (irq_out),
        .mode_q    (mode_q)
    );

endmodule

// File: rtl/irq_line_router_chk.sv
// Module: irq_line_router_chk
// Purpose: property checks on the router, attached by bind to the top.
// Assumes: the signal names inside irq_line_router are stable.
module irq_line_router_chk #(
    parameter int                 NUM_IRQ      = 16,
    parameter logic [NUM_IRQ-1:0] ALLOWED_MASK = 16'hDEB8,
    parameter int                 IRQ_W        = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_IRQ-1:0]     irq_out,
    input logic [NUM_IRQ-1:0]     irq_req,
    input logic [NUM_IRQ-1:0]     mode_q,
    input logic                   route_we,
    input logic                   route_dis,
    input logic [IRQ_W-1:0]       route_irq,
    input logic [4*IRQ_W+3:0]     route_state
);
    // R1: outputs are quiet in the first cycle out of reset.
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> irq_out == '0);

    // R8: a rejected write leaves the routing state untouched.
    p_reject_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (route_we && !route_dis && !ALLOWED_MASK[route_irq]) |=> $stable(route_state));

    genvar gi;
    generate
        for (gi = 0; gi < NUM_IRQ; gi++) begin : g_chk
            // R4: in level mode the output follows the request one cycle later.
            p_level_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
                !mode_q[gi] |=> irq_out[gi] == $past(irq_req[gi]));

            // R5: an edge-mode pulse lasts exactly one cycle.
            p_edge_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_q[gi] && irq_out[gi]) |=> !irq_out[gi]);

            // R10: no output without a request behind it.
            p_no_req_no_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
                irq_out[gi] |-> $past(irq_req[gi]));
        end
    endgenerate

endmodule

bind irq_line_router irq_line_router_chk #(
    .NUM_IRQ      (NUM_IRQ),
    .ALLOWED_MASK (ALLOWED_MASK),
    .IRQ_W        (IRQ_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_out     (irq_out),
    .irq_req     (irq_req),
    .mode_q      (mode_q),
    .route_we    (route_we),
    .route_dis   (route_dis),
    .route_irq   (route_irq),
    .route_state ({dis_q, tgt_q})
);

// File: tb/sim_irq_line_router.sv
// Bench: scoreboard for irq_line_router. Driver tasks push expected output
// vectors into a queue, and a monitor pops and compares them at the falling edge.
`timescale 1ns/100ps
module sim_irq_line_router;

    localparam int NS = 4;
    localparam int NI = 16;
    localparam int IW = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NS*4-1:0] slot_int_n = '1;
    logic           route_we = 1'b0;
    logic [1:0]     route_line = '0;
    logic           route_dis = 1'b0;
    logic [IW-1:0]  route_irq = '0;
    logic           mode_we = 1'b0;
    logic [IW-1:0]  mode_irq = '0;
    logic           mode_edge = 1'b0;
    logic [NI-1:0]  irq_out;

    always #2.5 clk = ~clk;

    irq_line_router u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_int_n (slot_int_n),
        .route_we   (route_we),
        .route_line (route_line),
        .route_dis  (route_dis),
        .route_irq  (route_irq),
        .mode_we    (mode_we),
        .mode_irq   (mode_irq),
        .mode_edge  (mode_edge),
        .irq_out    (irq_out)
    );

    typedef struct {
        logic [NI-1:0] exp;
        string         tag;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    // Pin index of slot s, pin p (bench-side model of the pin numbering).
    function automatic int pin_idx(input int s, input int p);
        return s * 4 + p;
    endfunction

    task automatic push_exp(input logic [NI-1:0] e, input string tag);
        item_t it;
        it.exp = e;
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic set_pins(input logic [NS*4-1:0] v);
        @(negedge clk);
        slot_int_n = v;
    endtask

    // Wait for the pin change to reach the output (third rising edge), then expect.
    task automatic settle_expect(input logic [NI-1:0] e, input string tag);
        repeat (3) @(posedge clk);
        push_exp(e, tag);
    endtask

    task automatic write_route(input int line, input bit dis, input int irq);
        @(negedge clk);
        route_we   = 1'b1;
        route_line = 2'(line);
        route_dis  = dis;
        route_irq  = IW'(irq);
        @(negedge clk);
        route_we   = 1'b0;
    endtask

    task automatic write_mode(input int irq, input bit edge_on);
        @(negedge clk);
        mode_we   = 1'b1;
        mode_irq  = IW'(irq);
        mode_edge = edge_on;
        @(negedge clk);
        mode_we   = 1'b0;
    endtask

    function automatic logic [NS*4-1:0] low_pins(input int a, input int b);
        logic [NS*4-1:0] v;
        v = '1;
        if (a >= 0) v[a] = 1'b0;
        if (b >= 0) v[b] = 1'b0;
        return v;
    endfunction

    // Monitor: compare every queued expectation at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (irq_out !== it.exp) begin
                    errors++;
                    $display("FAIL %s: irq_out=%h expected=%h", it.tag, irq_out, it.exp);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        push_exp('0, "R1 reset outputs low");

        // R2/R3/R4: default routes line l -> IRQ 9+l, all level mode.
        set_pins(low_pins(pin_idx(0, 0), -1));
        settle_expect(16'h0200, "R2 slot0 pin0 -> line0 -> IRQ9 (R1 default route)");
        set_pins(low_pins(pin_idx(1, 0), -1));
        settle_expect(16'h0400, "R2 slot1 pin0 -> line1 -> IRQ10");
        set_pins(low_pins(pin_idx(2, 3), -1));
        settle_expect(16'h0400, "R2 slot2 pin3 -> line1 -> IRQ10");
        set_pins(low_pins(pin_idx(3, 2), -1));
        settle_expect(16'h0400, "R2 slot3 pin2 -> line1 -> IRQ10");
        set_pins(low_pins(pin_idx(3, 0), -1));
        settle_expect(16'h1000, "R2 slot3 pin0 -> line3 -> IRQ12");

        // R3: two sharers on line1; dropping one keeps the line active.
        set_pins(low_pins(pin_idx(0, 1), pin_idx(1, 0)));
        settle_expect(16'h0400, "R3 two sharers on line1");
        set_pins(low_pins(pin_idx(1, 0), -1));
        settle_expect(16'h0400, "R3 one sharer remains");
        set_pins('1);
        settle_expect(16'h0000, "R4 level output falls with request");

        // R5: IRQ10 in edge mode.
        write_mode(10, 1'b1);
        set_pins(low_pins(pin_idx(0, 1), -1));
        settle_expect(16'h0400, "R5 rising edge pulse");
        @(posedge clk);
        push_exp(16'h0000, "R5 pulse lasts one cycle");
        @(posedge clk);
        push_exp(16'h0000, "R5 no repeat while held");
        set_pins('1);
        repeat (4) @(posedge clk);
        push_exp(16'h0000, "R5 no pulse on falling request");
        set_pins(low_pins(pin_idx(0, 1), -1));
        settle_expect(16'h0400, "R5 second rising edge pulses again");
        set_pins('1);
        repeat (4) @(posedge clk);

        // R6: move line0 to IRQ5 (permitted).
        write_route(0, 1'b0, 5);
        set_pins(low_pins(pin_idx(0, 0), -1));
        settle_expect(16'h0020, "R6 line0 rerouted to IRQ5");

        // R8: IRQ6 is not permitted; the route stays on IRQ5.
        write_route(0, 1'b0, 6);
        repeat (2) @(posedge clk);
        push_exp(16'h0020, "R8 forbidden target ignored");

        // R7: disable line2.
        set_pins('1);
        write_route(2, 1'b1, 11);
        set_pins(low_pins(pin_idx(0, 2), -1));
        settle_expect(16'h0000, "R7 disabled line drives nothing");

        // R9: line3 also to IRQ5.
        write_route(3, 1'b0, 5);
        set_pins(low_pins(pin_idx(0, 0), pin_idx(0, 3)));
        settle_expect(16'h0020, "R9 two lines merged on IRQ5");
        set_pins(low_pins(pin_idx(0, 3), -1));
        settle_expect(16'h0020, "R9 remaining line keeps IRQ5");

        // R10: all pins low; unrouted IRQs (9, 11, 12, ...) stay low.
        write_mode(10, 1'b0);
        set_pins('0);
        settle_expect(16'h0420, "R10 only routed IRQs active");

        set_pins('1);
        settle_expect(16'h0000, "R4 all released");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule